// File: doc/BRIEF.md
# Packed Integer to Floating-Point Converter

This block takes a 64-bit source vector that holds two signed integer lanes and turns each lane into an IEEE-754 value. There are four conversion modes. Two produce single precision from 16-bit words or 32-bit words and clear the upper half of the destination. One produces single precision from 32-bit words with nearest-even rounding and keeps the upper half of the old destination. The last produces two double-precision values that fill the whole destination. The caller presents the mode, the source vector and the old 128-bit destination image with a valid strobe. The merged destination image comes back one clock later.

The block is a single registered stage. Each lane uses a shared sign/magnitude and normalisation path. That path feeds both a single-precision packer, which rounds when needed, and a double-precision packer, which never needs to round. Outside the register, the block holds no state.

Top module: `pint2fp_conv`

## Requirements
- R1: Lane 0 is `src_vec[31:0]` and lane 1 is `src_vec[63:32]`. The result of lane 0 takes the lowest element position and the result of lane 1 takes the next one up: bits 31:0 and 63:32 for singles, or bits 63:0 and 127:64 for doubles.
- R2: Mode `2'b00` reads the low 16 bits of each 32-bit half as a signed word and ignores the upper 16 bits of that half. It writes two exact singles to bits 63:0 and forces bits 127:64 to zero.
- R3: Mode `2'b01` converts each 32-bit signed lane to single precision, rounding toward zero, and forces bits 127:64 to zero.
- R4: Mode `2'b10` converts each 32-bit signed lane to single precision using round-to-nearest with ties to even. Bits 127:64 of the result equal bits 127:64 of `dst_old`.
- R5: Mode `2'b11` converts each 32-bit signed lane to an exact double, and the two doubles fill all 128 bits.
- R6: An integer zero gives positive zero in every mode. The value -2^31 converts exactly: 0xCF000000 as a single, 0xC1E0000000000000 as a double.
- R7: `out_valid` equals the value `in_valid` had at the previous rising clock edge. While `rst_n` is low, both `out_valid` and `out_data` are zero.
- R8: When rounding up carries out of the fraction, the exponent increments. For example, 0x7FFFFFFF gives 0x4F000000 with nearest-even and 0x4EFFFFFF with truncation.
- R9: While `in_valid` is low, `out_data` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| in_mode | input | 2 | Conversion mode select |
| src_vec | input | 64 | Two packed signed integer lanes |
| dst_old | input | 128 | Previous destination contents |
| out_valid | output | 1 | Result valid, one cycle after strobe |
| out_data | output | 128 | Merged destination image |

## Verification
The hardest cases to reach are the single-precision rounding boundaries. These are exact ties at the guard bit, where the kept LSB decides the direction, and round-ups that carry into the exponent. Random 32-bit integers almost never land on them. The stimulus therefore places lanes at 2^24+1, 2^24+3, 0x7FFFFFFF and their negatives on purpose, and sends each of them through both the truncating and the nearest-even mode. For word mode, the stimulus fills the ignored upper halves with junk. Random operations, with idle gaps between them, then cover the remaining mode and value combinations.

// File: rtl/pi2f_pkg.sv
package pi2f_pkg;

   typedef enum logic [1:0] {
      CVT_W16_SP       = 2'b00,
      CVT_D32_SP_TRUNC = 2'b01,
      CVT_D32_SP_RNE   = 2'b10,
      CVT_D32_DP       = 2'b11
   } cvt_mode_e;

endpackage

// File: rtl/pi2f_msb_find.sv
module pi2f_msb_find #(
   parameter int W  = 32,
   parameter int PW = $clog2(W)
) (
   input  logic [W-1:0]  vec,
   output logic [PW-1:0] pos,
   output logic          any
);

   if (W < 2) begin : g_bad_w
      $error("pi2f_msb_find: W must be at least 2");
   end

   // Highest set bit wins: scan upward, later hits overwrite earlier ones.
   always_comb begin
      pos = '0;
      any = 1'b0;
      for (int i = 0; i < W; i++) begin
         if (vec[i]) begin
            pos = PW'(i);
            any = 1'b1;
         end
      end
   end

endmodule

// File: rtl/pi2f_lane.sv
module pi2f_lane #(
   parameter int LANE_W   = 32,
   parameter int SP_EXP_W = 8,
   parameter int SP_MAN_W = 23,
   parameter int DP_EXP_W = 11,
   parameter int DP_MAN_W = 52
) (
   input  logic [LANE_W-1:0]                lane_int,
   input  logic                             rne,
   output logic [SP_EXP_W+SP_MAN_W:0]       sp_bits,
   output logic [DP_EXP_W+DP_MAN_W:0]       dp_bits
);

   localparam int PW      = $clog2(LANE_W);
   localparam int SP_BIAS = (1 << (SP_EXP_W - 1)) - 1;
   localparam int DP_BIAS = (1 << (DP_EXP_W - 1)) - 1;
   localparam int FRAC_LO = LANE_W - 1 - SP_MAN_W;
   localparam int DP_PAD  = DP_MAN_W - (LANE_W - 1);
   localparam int SP_MAG_W = SP_EXP_W + SP_MAN_W;

   if (LANE_W < SP_MAN_W + 3) begin : g_bad_sp
      $error("pi2f_lane: LANE_W too narrow for guard and sticky bits");
   end
   if (DP_MAN_W < LANE_W) begin : g_bad_dp
      $error("pi2f_lane: double mantissa must hold the lane exactly");
   end
   if (LANE_W - 1 > SP_BIAS) begin : g_bad_exp
      $error("pi2f_lane: single exponent range too small for lane");
   end

   logic              sign;
   logic [LANE_W-1:0] mag;
   logic [LANE_W-1:0] norm;
   logic [PW-1:0]     msb_pos;
   logic [PW-1:0]     shamt;
   logic              nz;

   assign sign = lane_int[LANE_W-1];
   // Two's complement negate; the most negative value maps to 2^(LANE_W-1) unsigned.
   assign mag  = sign ? (~lane_int + 1'b1) : lane_int;

   pi2f_msb_find #(.W(LANE_W)) u_msb (
      .vec (mag),
      .pos (msb_pos),
      .any (nz)
   );

   assign shamt = PW'(LANE_W - 1) - msb_pos;
   assign norm  = mag << shamt;

   // Single precision path with optional nearest-even rounding.
   logic [SP_MAN_W-1:0] sp_frac;
   logic                guard_b;
   logic                sticky_b;
   logic                rnd_up;
   logic [SP_EXP_W-1:0] sp_exp;
   logic [SP_MAG_W-1:0] sp_mag;

   assign sp_frac  = norm[LANE_W-2:FRAC_LO];
   assign guard_b  = norm[FRAC_LO-1];
   assign sticky_b = |norm[FRAC_LO-2:0];
   assign rnd_up   = rne & guard_b & (sticky_b | sp_frac[0]);
   assign sp_exp   = SP_EXP_W'(SP_BIAS) + SP_EXP_W'(msb_pos);
   // A carry out of the fraction lands in the exponent field.
   assign sp_mag   = {sp_exp, sp_frac} + SP_MAG_W'(rnd_up);
   assign sp_bits  = nz ? {sign, sp_mag} : '0;

   // Double precision path: always exact.
   logic [DP_EXP_W-1:0] dp_exp;
   assign dp_exp  = DP_EXP_W'(DP_BIAS) + DP_EXP_W'(msb_pos);
   assign dp_bits = nz ? {sign, dp_exp, norm[LANE_W-2:0], {DP_PAD{1'b0}}} : '0;

endmodule

// File: rtl/pint2fp_conv.sv
module pint2fp_conv
   import pi2f_pkg::*;
#(
   parameter int LANES    = 2,
   parameter int LANE_W   = 32,
   parameter int WORD_W   = 16,
   parameter int SP_EXP_W = 8,
   parameter int SP_MAN_W = 23,
   parameter int DP_EXP_W = 11,
   parameter int DP_MAN_W = 52,
   localparam int SRC_W   = LANES * LANE_W,
   localparam int DST_W   = LANES * (1 + DP_EXP_W + DP_MAN_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [1:0]       in_mode,
   input  logic [SRC_W-1:0] src_vec,
   input  logic [DST_W-1:0] dst_old,
   output logic             out_valid,
   output logic [DST_W-1:0] out_data
);

   localparam int SP_W   = 1 + SP_EXP_W + SP_MAN_W;
   localparam int DP_W   = 1 + DP_EXP_W + DP_MAN_W;
   localparam int SP_ALL = LANES * SP_W;

   if (WORD_W >= LANE_W) begin : g_bad_word
      $error("pint2fp_conv: WORD_W must be narrower than LANE_W");
   end
   if (SP_ALL >= DST_W) begin : g_bad_dst
      $error("pint2fp_conv: single results must leave an upper region");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("pint2fp_conv: LANES must be positive");
   end

   cvt_mode_e mode;
   assign mode = cvt_mode_e'(in_mode);

   logic              word_sel;
   logic              rne_sel;
   assign word_sel = (mode == CVT_W16_SP);
   assign rne_sel  = (mode == CVT_D32_SP_RNE);

   logic [SP_ALL-1:0] sp_pack;
   logic [DST_W-1:0]  dp_pack;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] lane_raw;
      logic [LANE_W-1:0] lane_word;
      logic [LANE_W-1:0] lane_in;

      assign lane_raw  = src_vec[g*LANE_W +: LANE_W];
      assign lane_word = {{(LANE_W-WORD_W){lane_raw[WORD_W-1]}}, lane_raw[WORD_W-1:0]};
      assign lane_in   = word_sel ? lane_word : lane_raw;

      pi2f_lane #(
         .LANE_W   (LANE_W),
         .SP_EXP_W (SP_EXP_W),
         .SP_MAN_W (SP_MAN_W),
         .DP_EXP_W (DP_EXP_W),
         .DP_MAN_W (DP_MAN_W)
      ) u_lane (
         .lane_int (lane_in),
         .rne      (rne_sel),
         .sp_bits  (sp_pack[g*SP_W +: SP_W]),
         .dp_bits  (dp_pack[g*DP_W +: DP_W])
      );
   end

   logic [DST_W-1:0] merged;

   always_comb begin
      merged = '0;
      unique case (mode)
         CVT_W16_SP, CVT_D32_SP_TRUNC: begin
            merged[SP_ALL-1:0] = sp_pack;
         end
         CVT_D32_SP_RNE: begin
            merged             = dst_old;
            merged[SP_ALL-1:0] = sp_pack;
         end
         CVT_D32_DP: begin
            merged = dp_pack;
         end
         default: merged = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_data <= merged;
         end
      end
   end

endmodule

// File: rtl/pi2f_checker.sv
module pi2f_checker #(
   parameter int LANE_W = 32,
   parameter int SP_W   = 32,
   parameter int DP_W   = 64,
   parameter int SRC_W  = 64,
   parameter int DST_W  = 128,
   parameter int SP_ALL = 64
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [1:0]       in_mode,
   input logic [SRC_W-1:0] src_vec,
   input logic [DST_W-1:0] dst_old,
   input logic             out_valid,
   input logic [DST_W-1:0] out_data
);

   assert_valid_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   assert_valid_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_data));

   assert_word_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_mode == 2'b00) |=> (out_data[DST_W-1:SP_ALL] == '0));

   assert_trunc_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_mode == 2'b01) |=> (out_data[DST_W-1:SP_ALL] == '0));

   assert_rne_upper_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_mode == 2'b10) |=>
         (out_data[DST_W-1:SP_ALL] == $past(dst_old[DST_W-1:SP_ALL])));

   assert_dp_sign_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_mode == 2'b11) |=>
         (out_data[DP_W-1] == $past(src_vec[LANE_W-1])));

   assert_zero_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (in_mode == 2'b01 || in_mode == 2'b10) && src_vec[LANE_W-1:0] == '0)
         |=> (out_data[SP_W-1:0] == '0));

endmodule

bind pint2fp_conv pi2f_checker #(
   .LANE_W (LANE_W),
   .SP_W   (SP_W),
   .DP_W   (DP_W),
   .SRC_W  (SRC_W),
   .DST_W  (DST_W),
   .SP_ALL (SP_ALL)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_mode   (in_mode),
   .src_vec   (src_vec),
   .dst_old   (dst_old),
   .out_valid (out_valid),
   .out_data  (out_data)
);

// File: tb/sim_pint2fp_conv.sv
module sim_pint2fp_conv;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [1:0]   in_mode = 2'b00;
   logic [63:0]  src_vec = '0;
   logic [127:0] dst_old = '0;
   logic         out_valid;
   logic [127:0] out_data;

   int checks = 0;
   int errors = 0;

   logic [127:0] exp_q[$];
   string        req_q[$];
   logic [127:0] last_exp = '0;

   always #5 clk = ~clk;

   pint2fp_conv u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_mode   (in_mode),
      .src_vec   (src_vec),
      .dst_old   (dst_old),
      .out_valid (out_valid),
      .out_data  (out_data)
   );

   // Reference single conversion by integer division, independent of the RTL.
   function automatic logic [31:0] ref_sp(input int v, input bit rne);
      longint a, q, rem, half;
      int     k, ex;
      logic   s;
      if (v == 0) return 32'h0;
      s = (v < 0);
      a = s ? -longint'(v) : longint'(v);
      q = a;
      k = 0;
      while (q >= 64'sd16777216) begin
         q = q / 2;
         k++;
      end
      rem = a - q * (longint'(1) << k);
      if (rne && k > 0) begin
         half = longint'(1) << (k - 1);
         if (rem > half || (rem == half && (q % 2) == 1)) q = q + 1;
         if (q == 64'sd16777216) begin
            q = q / 2;
            k++;
         end
      end
      while (q < 64'sd8388608) begin
         q = q * 2;
         k--;
      end
      ex = 150 + k;
      return {s, ex[7:0], q[22:0]};
   endfunction

   function automatic logic [63:0] ref_dp(input int v);
      return $realtobits(real'(v));
   endfunction

   function automatic logic [127:0] ref_out(input logic [1:0] m, input logic [63:0] s,
                                            input logic [127:0] d);
      int l0, l1;
      l0 = int'(s[31:0]);
      l1 = int'(s[63:32]);
      case (m)
         2'b00: return {64'h0, ref_sp(int'($signed(s[47:32])), 1'b0),
                        ref_sp(int'($signed(s[15:0])), 1'b0)};
         2'b01: return {64'h0, ref_sp(l1, 1'b0), ref_sp(l0, 1'b0)};
         2'b10: return {d[127:64], ref_sp(l1, 1'b1), ref_sp(l0, 1'b1)};
         default: return {ref_dp(l1), ref_dp(l0)};
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input logic [127:0] act,
                        input logic [127:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   // Driver: one operation, expectation pushed to the scoreboard.
   task automatic send(input logic [1:0] m, input logic [63:0] s, input logic [127:0] d,
                       input string req);
      @(negedge clk);
      in_valid = 1'b1;
      in_mode  = m;
      src_vec  = s;
      dst_old  = d;
      exp_q.push_back(ref_out(m, s, d));
      req_q.push_back(req);
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid = 1'b0;
      in_mode  = 2'($urandom);
      src_vec  = {$urandom, $urandom};
      dst_old  = {$urandom, $urandom, $urandom, $urandom};
   endtask

   // Monitor: compare each valid result against the front of the scoreboard.
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R7 unexpected out_valid", out_data, '0);
         end else begin
            logic [127:0] e;
            string        r;
            e = exp_q.pop_front();
            r = req_q.pop_front();
            last_exp = e;
            check(out_data === e, r, out_data, e);
         end
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [127:0] junk;
      junk = 128'hDEAD_BEEF_0123_4567_89AB_CDEF_5555_AAAA;

      // Reset state (R7)
      in_valid = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(out_valid === 1'b0, "R7 reset out_valid", {127'h0, out_valid}, '0);
      check(out_data === '0, "R7 reset out_data", out_data, '0);
      in_valid = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid === 1'b0, "R7 idle after reset", {127'h0, out_valid}, '0);

      // Word mode with junk in the ignored upper halves (R2, R1)
      send(2'b00, {16'hABCD, 16'h8000, 16'h1234, 16'h7FFF}, junk, "R2 word extremes");
      send(2'b00, {16'hFFFF, 16'hFFFF, 16'h0000, 16'h0000}, junk, "R2 word -1 and zero R6");
      send(2'b00, {16'h0000, 16'h0005, 16'hFFFF, 16'hFF9C}, junk, "R1 word lane order");
      // Truncation (R3, R8)
      send(2'b01, {32'h0100_0001, 32'h7FFF_FFFF}, junk, "R3 R8 truncate max");
      send(2'b01, {32'hFEFF_FFFD, 32'h0100_0003}, junk, "R3 truncate neg");
      send(2'b01, {32'h8000_0000, 32'h0000_0000}, junk, "R6 trunc min and zero");
      // Nearest even (R4, R8)
      send(2'b10, {32'h0100_0001, 32'h7FFF_FFFF}, junk, "R4 R8 rne max tie-even");
      send(2'b10, {32'hFEFF_FFFD, 32'h0100_0003}, junk, "R4 rne tie-up");
      send(2'b10, {32'h8000_0000, 32'h0000_0000}, junk, "R6 rne min and zero");
      send(2'b10, {32'h0000_0003, 32'h00FF_FFFF}, ~junk, "R4 exact small");
      // Double (R5, R6)
      send(2'b11, {32'h8000_0000, 32'h0000_0001}, junk, "R5 R6 dp min");
      send(2'b11, {32'h7FFF_FFFF, 32'hFFFF_FFFF}, junk, "R5 dp max and -1");
      send(2'b11, {32'h0000_0000, 32'h1234_5678}, junk, "R6 dp zero R1");

      // Hold while idle (R9)
      idle();
      idle();
      idle();
      @(negedge clk);
      check(out_valid === 1'b0, "R7 valid drops", {127'h0, out_valid}, '0);
      check(out_data === last_exp, "R9 hold while idle", out_data, last_exp);

      // Random operations with gaps
      for (int i = 0; i < 240; i++) begin
         logic [1:0] m;
         string      r;
         m = 2'(i % 4);
         r = (m == 2'b00) ? "R2 random" : (m == 2'b01) ? "R3 random" :
             (m == 2'b10) ? "R4 random" : "R5 random";
         send(m, {$urandom, $urandom}, {$urandom, $urandom, $urandom, $urandom}, r);
         if ($urandom_range(0, 3) == 0) idle();
      end
      idle();
      repeat (4) @(negedge clk);
      check(exp_q.size() == 0, "R7 all results returned", 128'(exp_q.size()), '0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule